// File: doc/BRIEF.md
# Triggered Parent Clock Selector

This block picks one of several parent clocks and drives it onto a single clock output. Software stages a selector code in a field of a 32-bit register. The staged code has no effect on the output until software writes the trigger. The trigger then reads back as busy until the hand-over has finished. A parameter table maps each packed parent index to its hardware code. The field can hold more codes than there are parents, and the reset code is chosen so that it matches none of them. A committed code with no matching parent leaves the output parked low.

The hand-over is break-before-make. The control logic first drops the request for the old parent. Each request is synchronised into its own source domain on the falling edge of that source, then reported back to the control clock. Only after every enable is seen low does the request for the new parent go up. An enable therefore only changes while its source is low, so no runt pulse reaches the output. A trigger is accepted only while the clock-enable input is high and no switch is in flight.

Top module: `trig_clk_sel`

## Requirements
- R1: After reset the readback is RESET_CODE (default 7) at bits [SEL_SHIFT+SEL_W-1:SEL_SHIFT] (default [6:4]), all other bits 0. Busy is 0, the active index is 255 and the clock output is low.
- R2: A register write copies bits [SEL_SHIFT+SEL_W-1:SEL_SHIFT] of the write data into the staged field and ignores every other bit. The write leaves the active index and the clock output unchanged.
- R3: A trigger write while clk_en_i is high makes busy read 1 from the next clock edge on. Busy returns to 0 once the switch is complete.
- R4: A trigger write while clk_en_i is low is ignored. Busy stays 0 and the active index is unchanged.
- R5: With the default table, code 0 maps to index 0, code 1 to index 1, code 3 to index 2 and code 6 to index 3. After a committed switch, active_idx_o holds that index and clk_o follows that parent.
- R6: Codes 2, 4, 5 and 7 match no parent. Committing one of them still clears busy, sets the active index to 255 and holds clk_o low.
- R7: A trigger write while busy is 1 is ignored. It is not queued, so the running switch completes to its original target and busy then stays 0.
- R8: During a switch the active index reads 255, and at most one parent enable is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Clock enabled; a trigger is accepted only while high |
| sel_wr_i | input | 1 | Selector register write strobe |
| sel_wdata_i | input | 32 | Selector register write data |
| trig_wr_i | input | 1 | Write of 1 to the trigger bit |
| src_clk_i | input | N_SRC | Parent clocks |
| sel_reg_o | output | 32 | Selector register readback (staged field) |
| trig_busy_o | output | 1 | Trigger readback: 1 while a switch is in progress |
| active_idx_o | output | 8 | Packed index of the live parent, 255 when none |
| clk_o | output | 1 | Selected clock |

## Verification
The bench uses the defaults: four parents, a 3-bit field at shift 4, codes {0,1,3,6} and reset code 7. This leaves four of the eight codes invalid, including the reset code. Switches therefore run from no parent to a parent, between parents, from a parent to no parent, and from no parent back again. The four parent clocks run at unrelated rates, so the drop and raise handshakes each take a different number of control cycles. The enable and busy rules are also exercised against a switch that is in flight.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam logic [7:0] NO_SRC = 8'hFF;
  typedef enum logic [1:0] {ST_IDLE, ST_DROP, ST_RAISE} sw_state_e;
endpackage

// File: rtl/tcs_code_map.sv
module tcs_code_map #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 3,
  parameter logic [N_SRC*SEL_W-1:0] CODES = '0
) (
  input  logic [SEL_W-1:0] code_i,
  output logic [7:0]       idx_o
);
  import tcs_pkg::*;

  // lowest index wins if the table holds a code twice
  always_comb begin
    idx_o = NO_SRC;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (CODES[i*SEL_W +: SEL_W] == code_i) idx_o = 8'(i);
    end
  end
endmodule

// File: rtl/tcs_gate_sync.sv
module tcs_gate_sync #(
  parameter int N_SRC  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_clk_i,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] gate_en_o,
  output logic [N_SRC-1:0] ack_o,
  output logic             clk_o
);
  logic [N_SRC-1:0] gated;
  logic [N_SRC-1:0] ack_meta;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [STAGES-1:0] sync_q;
    // falling-edge capture: enable only moves while the source is low
    always_ff @(negedge src_clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[STAGES-2:0], req_i[g]};
    end
    assign gate_en_o[g] = sync_q[STAGES-1];
    assign gated[g]     = src_clk_i[g] & gate_en_o[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_meta <= '0;
      ack_o    <= '0;
    end else begin
      ack_meta <= gate_en_o;
      ack_o    <= ack_meta;
    end
  end

  assign clk_o = |gated;
endmodule

// File: rtl/tcs_switch_ctl.sv
module tcs_switch_ctl #(
  parameter int N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             clk_en_i,
  input  logic [7:0]       tgt_idx_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] req_o,
  output logic             busy_o,
  output logic [7:0]       act_idx_o
);
  import tcs_pkg::*;

  sw_state_e        state_q;
  logic [7:0]       tgt_q;
  logic [N_SRC-1:0] tgt_oh;
  logic             tgt_ack;

  always_comb begin
    tgt_oh = '0;
    for (int i = 0; i < N_SRC; i++) tgt_oh[i] = (tgt_q == 8'(i));
  end
  assign tgt_ack = |(ack_i & tgt_oh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tgt_q     <= NO_SRC;
      req_o     <= '0;
      act_idx_o <= NO_SRC;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_i && clk_en_i) begin
          tgt_q     <= tgt_idx_i;
          req_o     <= '0;
          act_idx_o <= NO_SRC;
          state_q   <= ST_DROP;
        end
        ST_DROP: if (ack_i == '0) begin
          if (|tgt_oh) begin
            req_o   <= tgt_oh;
            state_q <= ST_RAISE;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_RAISE: if (tgt_ack) begin
          act_idx_o <= tgt_q;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/trig_clk_sel.sv
module trig_clk_sel #(
  parameter int N_SRC = 4,
  parameter int SEL_SHIFT = 4,
  parameter int SEL_W = 3,
  parameter logic [N_SRC*SEL_W-1:0] PAR_CODES = 12'b110_011_001_000,
  parameter logic [SEL_W-1:0] RESET_CODE = 3'd7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             sel_wr_i,
  input  logic [31:0]      sel_wdata_i,
  input  logic             trig_wr_i,
  input  logic [N_SRC-1:0] src_clk_i,
  output logic [31:0]      sel_reg_o,
  output logic             trig_busy_o,
  output logic [7:0]       active_idx_o,
  output logic             clk_o
);
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       map_idx;
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] ack;
  logic [N_SRC-1:0] gate_en;
  logic             unused_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= RESET_CODE;
    else if (sel_wr_i) sel_q <= sel_wdata_i[SEL_SHIFT +: SEL_W];
  end

  assign sel_reg_o    = 32'(sel_q) << SEL_SHIFT;
  assign unused_wdata = ^sel_wdata_i;

  tcs_code_map #(.N_SRC(N_SRC), .SEL_W(SEL_W), .CODES(PAR_CODES)) i_map (
    .code_i (sel_q),
    .idx_o  (map_idx)
  );

  tcs_switch_ctl #(.N_SRC(N_SRC)) i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_wr_i),
    .clk_en_i  (clk_en_i),
    .tgt_idx_i (map_idx),
    .ack_i     (ack),
    .req_o     (req),
    .busy_o    (trig_busy_o),
    .act_idx_o (active_idx_o)
  );

  tcs_gate_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_clk_i (src_clk_i),
    .req_i     (req),
    .gate_en_o (gate_en),
    .ack_o     (ack),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_i,
  input logic             trig_wr_i,
  input logic             trig_busy_o,
  input logic [7:0]       active_idx_o,
  input logic [N_SRC-1:0] gate_en,
  input logic             clk_o
);
  a_r3_busy_needs_trig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_busy_o) |-> $past(trig_wr_i && clk_en_i));

  a_r4_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_busy_o && trig_wr_i && !clk_en_i) |=> !trig_busy_o);

  a_r2_idx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_busy_o && !(trig_wr_i && clk_en_i)) |=> $stable(active_idx_o));

  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_idx_o < 8'(N_SRC)) || (active_idx_o == 8'hFF));

  a_r6_parked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_busy_o && active_idx_o == 8'hFF) |-> !clk_o);

  a_r8_idx_none_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_busy_o |-> (active_idx_o == 8'hFF));

  a_r8_one_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate_en));
endmodule

bind trig_clk_sel tcs_chk #(.N_SRC(N_SRC)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_en_i     (clk_en_i),
  .trig_wr_i    (trig_wr_i),
  .trig_busy_o  (trig_busy_o),
  .active_idx_o (active_idx_o),
  .gate_en      (gate_en),
  .clk_o        (clk_o)
);

// File: tb/test_trig_clk_sel.sv
`timescale 1ns/1ps
module test_trig_clk_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  logic        sel_wr_i = 1'b0;
  logic [31:0] sel_wdata_i = '0;
  logic        trig_wr_i = 1'b0;
  logic [3:0]  src_clk_i = '0;
  logic [31:0] sel_reg_o;
  logic        trig_busy_o;
  logic [7:0]  active_idx_o;
  logic        clk_o;

  int n_run = 0;
  int n_fail = 0;
  int n_sent = 0;
  int mon_done = 0;
  logic [7:0] exp_q[$];
  logic [1:0] mon_idx = '0;
  logic       mon_src;

  trig_clk_sel i_trig_clk_sel (
    .clk_i, .rst_ni, .clk_en_i, .sel_wr_i, .sel_wdata_i, .trig_wr_i,
    .src_clk_i, .sel_reg_o, .trig_busy_o, .active_idx_o, .clk_o
  );

  always #5 clk_i = ~clk_i;
  always #3 src_clk_i[0] = ~src_clk_i[0];
  always #7 src_clk_i[1] = ~src_clk_i[1];
  always #11 src_clk_i[2] = ~src_clk_i[2];
  always #17 src_clk_i[3] = ~src_clk_i[3];
  assign mon_src = src_clk_i[mon_idx];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check_low(input string req);
    int hi = 0;
    for (int k = 0; k < 60; k++) begin
      #1.7;
      if (clk_o) hi++;
    end
    chk(hi == 0, req, hi, 0);
  endtask

  task automatic wr_sel(input logic [31:0] d);
    @(negedge clk_i);
    sel_wr_i = 1'b1; sel_wdata_i = d;
    @(negedge clk_i);
    sel_wr_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk_i);
    trig_wr_i = 1'b1;
    @(negedge clk_i);
    trig_wr_i = 1'b0;
  endtask

  // driver: stage expectation, commit, check busy/none, wait for monitor
  task automatic do_switch(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    n_sent++;
    pulse_trig();
    chk(trig_busy_o == 1'b1, "R3 busy set", int'(trig_busy_o), 1);
    chk(active_idx_o == 8'hFF, "R8 none during switch", int'(active_idx_o), 255);
    wait (mon_done == n_sent);
    chk(trig_busy_o == 1'b0, req, int'(trig_busy_o), 0);
  endtask

  // monitor: on completion compare index and the live clock
  initial begin
    forever begin
      @(negedge trig_busy_o);
      #2;
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(active_idx_o == e, "R5 R6 active index", int'(active_idx_o), int'(e));
        if (e == 8'hFF) begin
          check_low("R6 output parked low");
        end else begin
          int bad = 0;
          mon_idx = e[1:0];
          #0.1;
          for (int k = 0; k < 6; k++) begin
            @(mon_src);
            #0.2;
            if (clk_o !== mon_src) bad++;
          end
          chk(bad == 0, "R5 clock follows parent", bad, 0);
        end
        mon_done++;
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(sel_reg_o == 32'h70, "R1 reset readback", int'(sel_reg_o), 32'h70);
    chk(trig_busy_o == 1'b0, "R1 busy idle", int'(trig_busy_o), 0);
    chk(active_idx_o == 8'hFF, "R1 active none", int'(active_idx_o), 255);
    check_low("R1 output low");

    // R2 staging only, other bits ignored
    wr_sel(32'hA5A5_A53A);
    chk(sel_reg_o == 32'h30, "R2 staged field", int'(sel_reg_o), 32'h30);
    repeat (8) @(negedge clk_i);
    chk(active_idx_o == 8'hFF, "R2 no effect before trigger", int'(active_idx_o), 255);
    check_low("R2 output still low");

    // R5 mapping over all valid codes
    do_switch(8'd2, "R3 busy cleared code3");
    wr_sel(32'h60); do_switch(8'd3, "R3 busy cleared code6");
    wr_sel(32'h00); do_switch(8'd0, "R3 busy cleared code0");
    wr_sel(32'h10); do_switch(8'd1, "R3 busy cleared code1");

    // R6 invalid codes
    wr_sel(32'h50); do_switch(8'hFF, "R6 busy cleared code5");
    wr_sel(32'h10); do_switch(8'd1, "R5 from none to code1");
    wr_sel(32'h20); do_switch(8'hFF, "R6 busy cleared code2");
    wr_sel(32'h30); do_switch(8'd2, "R5 from none to code3");

    // R4 trigger with clock disabled
    clk_en_i = 1'b0;
    wr_sel(32'h00);
    pulse_trig();
    chk(trig_busy_o == 1'b0, "R4 no busy when disabled", int'(trig_busy_o), 1'b0);
    repeat (20) @(negedge clk_i);
    chk(active_idx_o == 8'd2, "R4 index unchanged", int'(active_idx_o), 2);
    clk_en_i = 1'b1;

    // R7 retrigger while busy
    exp_q.push_back(8'd0);
    n_sent++;
    pulse_trig();
    chk(trig_busy_o == 1'b1, "R7 first trigger busy", int'(trig_busy_o), 1);
    wr_sel(32'h60);
    pulse_trig();
    wait (mon_done == n_sent);
    repeat (20) @(negedge clk_i);
    chk(trig_busy_o == 1'b0, "R7 retrigger not queued", int'(trig_busy_o), 0);
    chk(active_idx_o == 8'd0, "R7 original target kept", int'(active_idx_o), 0);

    // staged code 6 still commits on a later trigger
    do_switch(8'd3, "R7 later trigger accepted");
    finish_run();
  end
endmodule